// File: doc/BRIEF.md
# Activate Rate Limiter

This block polices the rate of row-activate commands sent to one rank of a DRAM device, across all of its banks. A command scheduler raises a one-cycle strobe each time it issues an activate. In return the block tells the scheduler, through a combinational permit flag for the current cycle, whether a new activate may legally go out now.

Two rules gate the permit. The first is a minimum spacing between any two activates, counted in clock cycles. The second is a rolling window: no span of the window length may hold more than a set number of activates. That number is normally 4 and may also be 2. The window rule is switched off by giving the window length the value zero, which leaves only the spacing rule in force.

The block keeps one elapsed-time counter per activate still inside the window, in a circular buffer. A strobe that arrives while the permit is low is not recorded. It raises a sticky violation flag instead.

Top module: `act_rate_limiter`

## Requirements
- R1: After reset, act_ok is 1 and act_viol is 0.
- R2: An activate is accepted in a cycle where act_strobe and act_ok are both 1. After an activate accepted in cycle t, act_ok is 0 in cycles t+1 to t+GAP_CYC-1. GAP_CYC defaults to 5.
- R3: With WIN_CYC > 0, act_ok is 0 in cycle t whenever the ACT_LIMIT-th most recent accepted activate happened in a cycle later than t-WIN_CYC. WIN_CYC defaults to 32 and ACT_LIMIT to 4.
- R4: Until ACT_LIMIT activates have been accepted since reset, only the spacing rule of R2 gates act_ok.
- R5: With WIN_CYC = 0, act_ok depends only on the spacing rule, at any activate rate.
- R6: ACT_LIMIT = 2 is supported, with R3 applying to the second most recent accepted activate.
- R7: A strobe in a cycle where act_ok is 0 sets act_viol from the next cycle on. It is not recorded, so it changes neither the spacing nor the window state.
- R8: Once set, act_viol stays 1 until reset.
- R9: act_ok is 1 in cycle t exactly when both the spacing rule and the window rule permit an activate in cycle t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| act_strobe | input | 1 | Activate issued in this cycle |
| act_ok | output | 1 | An activate is permitted in this cycle |
| act_viol | output | 1 | Sticky flag: a strobe arrived while act_ok was 0 |

## Verification
The bench drives greedy bursts that strobe in every cycle the permit allows. These hit the exact cycle where the oldest buffered activate leaves the window. An off-by-one in the age compare would show as a permit that opens one cycle early or late, and a wrong buffer pointer would show as the window closing after the wrong count.

Three instances run side by side: a limit of 4, a limit of 2, and the window disabled. A design that ignored the zero-length window would throttle the third instance. Strobes sent while the permit is low check that the flag is sticky and that the spacing and window state are untouched: a design that recorded these strobes would close the permit at the wrong times. A second reset checks that the violation flag clears.

// File: rtl/act_rl_pkg.sv
package act_rl_pkg;
  // width of a counter that must hold values 0..v, never narrower than one bit
  function automatic int cnt_w(input int v);
    int w;
    w = $clog2(v + 1);
    return (w < 1) ? 1 : w;
  endfunction
endpackage

// File: rtl/arl_rst_sync.sv
module arl_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/arl_gap_timer.sv
module arl_gap_timer
  import act_rl_pkg::*;
#(
  parameter int GAP_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_go,
  output logic gap_ok
);
  localparam int GW = cnt_w(GAP_CYC);
  localparam logic [GW-1:0] GAP_V = GW'(GAP_CYC);

  logic [GW-1:0] since_q, since_d;
  logic          since_en;

  // cycles since the last accepted activate, saturating at the gap
  always_comb begin
    since_en = act_go || (since_q < GAP_V);
    since_d  = act_go ? GW'(1) : since_q + GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        since_q <= GAP_V;
    else if (since_en) since_q <= since_d;
  end

  assign gap_ok = (since_q >= GAP_V);

  // R2: the spacing permit only ever closes because of an accepted activate
  p_gap_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gap_ok) |-> $past(act_go));

  generate
    if (GAP_CYC > 1) begin : g_hold_chk
      // R2: the cycle after an accepted activate is always blocked
      p_gap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |=> !gap_ok);
    end
  endgenerate
endmodule

// File: rtl/arl_window_track.sv
module arl_window_track
  import act_rl_pkg::*;
#(
  parameter int WIN_CYC   = 32,
  parameter int ACT_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_go,
  output logic win_ok
);
  generate
    if (WIN_CYC == 0) begin : g_off
      // R5: window rule disabled
      assign win_ok = 1'b1;
    end else begin : g_on
      localparam int AW = cnt_w(WIN_CYC);
      localparam int PW = (ACT_LIMIT > 1) ? $clog2(ACT_LIMIT) : 1;
      localparam logic [AW-1:0] WIN_V  = AW'(WIN_CYC);
      localparam logic [PW-1:0] LAST_P = PW'(ACT_LIMIT - 1);

      logic [AW-1:0] age_q [ACT_LIMIT];
      logic [AW-1:0] age_d [ACT_LIMIT];
      logic [PW-1:0] wp_q, wp_d;

      // slot at the write pointer holds the oldest of the last ACT_LIMIT
      always_comb begin
        for (int i = 0; i < ACT_LIMIT; i++) begin
          if (act_go && (PW'(i) == wp_q)) age_d[i] = AW'(1);
          else if (age_q[i] < WIN_V)      age_d[i] = age_q[i] + AW'(1);
          else                            age_d[i] = age_q[i];
        end
        if (!act_go)              wp_d = wp_q;
        else if (wp_q == LAST_P)  wp_d = '0;
        else                      wp_d = wp_q + PW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wp_q <= '0;
          for (int i = 0; i < ACT_LIMIT; i++) age_q[i] <= WIN_V;
        end else begin
          wp_q <= wp_d;
          for (int i = 0; i < ACT_LIMIT; i++) age_q[i] <= age_d[i];
        end
      end

      assign win_ok = (age_q[wp_q] >= WIN_V);

      // R3: the window permit only closes right after an accepted activate
      p_win_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(win_ok) |-> $past(act_go));
    end
  endgenerate
endmodule

// File: rtl/act_rate_limiter.sv
module act_rate_limiter
  import act_rl_pkg::*;
#(
  parameter int GAP_CYC   = 5,
  parameter int WIN_CYC   = 32,
  parameter int ACT_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_strobe,
  output logic act_ok,
  output logic act_viol
);
  logic rst_s_n;
  logic gap_ok, win_ok, act_go, bad_req;
  logic viol_q, viol_d;

  arl_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s_n)
  );

  arl_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .act_go (act_go),
    .gap_ok (gap_ok)
  );

  arl_window_track #(.WIN_CYC(WIN_CYC), .ACT_LIMIT(ACT_LIMIT)) u_win (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .act_go (act_go),
    .win_ok (win_ok)
  );

  always_comb begin
    act_ok  = gap_ok && win_ok;
    act_go  = act_strobe && act_ok;
    bad_req = act_strobe && !act_ok;
    viol_d  = viol_q || bad_req;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) viol_q <= 1'b0;
    else          viol_q <= viol_d;
  end

  assign act_viol = viol_q;

  // R7: a blocked strobe raises the violation flag next cycle
  p_viol_set_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (act_strobe && !act_ok) |=> act_viol);

  // R8: the violation flag is sticky
  p_viol_sticky_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    act_viol |=> act_viol);
endmodule

// File: tb/sim_act_rate_limiter.sv
`timescale 1ns/1ps
module sim_act_rate_limiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] strb = 3'b000;
  logic ok_w [3];
  logic viol_w [3];

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // instance 0: defaults (gap 5, window 32, limit 4)
  act_rate_limiter u0 (.clk(clk), .rst_n(rst_n), .act_strobe(strb[0]),
                       .act_ok(ok_w[0]), .act_viol(viol_w[0]));
  // instance 1: window disabled
  act_rate_limiter #(.GAP_CYC(3), .WIN_CYC(0), .ACT_LIMIT(4)) u1 (
    .clk(clk), .rst_n(rst_n), .act_strobe(strb[1]),
    .act_ok(ok_w[1]), .act_viol(viol_w[1]));
  // instance 2: limit of two
  act_rate_limiter #(.GAP_CYC(2), .WIN_CYC(12), .ACT_LIMIT(2)) u2 (
    .clk(clk), .rst_n(rst_n), .act_strobe(strb[2]),
    .act_ok(ok_w[2]), .act_viol(viol_w[2]));

  // reference model built from the requirements
  int gap_p [3] = '{5, 3, 2};
  int win_p [3] = '{32, 0, 12};
  int lim_p [3] = '{4, 4, 2};
  int hist [3][4];
  int hcnt [3];
  int hwp  [3];
  int last [3];
  bit mviol [3];
  int cyc;

  function automatic bit exp_ok(input int i);
    bit g, w;
    g = (cyc - last[i]) >= gap_p[i];
    w = (win_p[i] == 0) || (hcnt[i] < lim_p[i]) ||
        ((cyc - hist[i][hwp[i]]) >= win_p[i]);
    return g && w;
  endfunction

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      hcnt[i] = 0; hwp[i] = 0; last[i] = -100000; mviol[i] = 0;
    end
    cyc = 0;
  endtask

  // called at a falling edge: compare, drive, advance one cycle
  task automatic step(input logic [2:0] s, input string tag);
    for (int i = 0; i < 3; i++) begin
      chk(ok_w[i] === exp_ok(i), $sformatf("%s ok inst%0d", tag, i), ok_w[i], exp_ok(i));
      chk(viol_w[i] === mviol[i], $sformatf("R7 R8 viol inst%0d", i), viol_w[i], mviol[i]);
    end
    strb = s;
    for (int i = 0; i < 3; i++) begin
      if (s[i] && exp_ok(i)) begin
        last[i] = cyc;
        hist[i][hwp[i]] = cyc;
        hwp[i] = (hwp[i] == lim_p[i] - 1) ? 0 : hwp[i] + 1;
        if (hcnt[i] < lim_p[i]) hcnt[i]++;
      end else if (s[i]) begin
        mviol[i] = 1;
      end
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  function automatic logic [2:0] greedy();
    return {exp_ok(2), exp_ok(1), exp_ok(0)};
  endfunction

  task automatic do_reset();
    strb = 3'b000;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    model_reset();
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin
      chk(ok_w[i] === 1'b1, "R1 ok after reset", ok_w[i], 1);
      chk(viol_w[i] === 1'b0, "R1 viol after reset", viol_w[i], 0);
    end
  endtask

  task automatic t_gap();
    step(3'b111, "R2 R9 single act");
    repeat (8) step(3'b000, "R2 gap countdown");
  endtask

  task automatic t_burst();
    // greedy: strobe whenever permitted, R4 early then R3/R6 window, R5 no window
    repeat (90) step(greedy(), "R3 R4 R5 R6 burst");
    repeat (40) step(3'b000, "R3 drain");
  endtask

  task automatic t_viol();
    step(3'b111, "R2 act before blocked strobe");
    step(3'b111, "R7 blocked strobe");
    repeat (6) step(3'b000, "R7 timing unaffected");
    repeat (30) step(greedy(), "R7 R3 after violation");
    repeat (5) step(3'b000, "R8 sticky");
  endtask

  task automatic t_random();
    logic [15:0] lf = 16'hACE1;
    repeat (300) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step({lf[2] & lf[9], lf[1] & lf[7], lf[0] & lf[5]}, "R3 R7 R9 random");
    end
  endtask

  task automatic t_reset_clears();
    do_reset();
    for (int i = 0; i < 3; i++)
      chk(viol_w[i] === 1'b0, "R8 viol cleared by reset", viol_w[i], 0);
    repeat (40) step(greedy(), "R4 R3 after second reset");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    model_reset();
    do_reset();
    t_reset();
    t_gap();
    t_burst();
    t_viol();
    t_random();
    t_reset_clears();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end
endmodule